// File: doc/BRIEF.md
# Indirect Register Window

This block is the host-facing front of a storage-bus controller. It holds thirty-two byte-wide registers and exposes them through two host locations. The first location holds a 5-bit index. The second location opens a window onto whichever register that index selects. A host first writes the index and then streams accesses through the window. After each window access the index moves on by itself, except on a few registers that the host must hit repeatedly.

Some register touches do more than store or return a byte. A write to the command register marks a command as in progress and hands the low seven bits to the command engine as a one-cycle launch pulse. A write to the first descriptor byte clears the phase register. A read of the bus status register acknowledges the pending interrupt. The interrupt line follows the interrupt-pending bit of the auxiliary status register. Command execution and the bus-side data path are outside this block.

Top module: `regwin_top`

## Requirements
- R1: After a synchronous reset, every register, the index, `rd_data`, `irq` and `cmd_start` are zero.
- R2: A write at `port_sel` = 0 loads the index with bits 4:0 of `wr_data`; bits 7:5 are dropped.
- R3: A read at `port_sel` = 0 returns the auxiliary status register (index 0x1A) whatever the index holds, and leaves the index unchanged.
- R4: A read or write at `port_sel` = 1 returns or stores the register the index selects. Afterwards the index advances by one, modulo 32, so 0x1F is followed by 0x00.
- R5: The index does not advance after a window access while it selects the command register (0x18), the data register (0x19) or the auxiliary status register (0x1A).
- R6: A window write to the command register stores the full byte and sets bit 4 (command in progress) of auxiliary status. On the next cycle `cmd_start` is high for exactly one cycle, and `cmd_code` carries bits 6:0 of the written byte.
- R7: A window write to the first descriptor-byte register (0x03) clears the phase register (0x10) to zero.
- R8: `irq` equals bit 7 (interrupt pending) of auxiliary status. A window read of the bus status register (0x17) returns its value and clears that bit, so `irq` goes low.
- R9: Writes at `port_sel` = 2 or 3 change nothing: no register, no index, no command launch. Reads there return zero.
- R10: Read data is registered. It appears on `rd_data` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_sel | input | 2 | Host location: 0 index/aux status, 1 window, 2-3 unused |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| cmd_start | output | 1 | One-cycle command launch pulse |
| cmd_code | output | 7 | Command code sent with the pulse |
| irq | output | 1 | Interrupt request, the interrupt-pending bit |

## Verification
The assertions assume that a host never raises `wr_en` and `rd_en` in the same cycle. If it does, the write is taken and the read is dropped, and the read-side checks do not cover that cycle. They also assume a single-cycle strobe for each access, because each access advances the index once. The stimulus drives one strobe per two-cycle slot and never overlaps the two. It exercises the wrap from 0x1F to 0x00, every register that holds the index fixed, and every side-effect register, including back-to-back accesses to the registers that hold the index fixed.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int DATA_W = 8;
    localparam int PTR_W  = 5;
    localparam int NREG   = 1 << PTR_W;
    localparam int CODE_W = 7;
    localparam int SEL_W  = 2;

    localparam logic [PTR_W-1:0] IDX_CDB1   = 5'h03;
    localparam logic [PTR_W-1:0] IDX_PHASE  = 5'h10;
    localparam logic [PTR_W-1:0] IDX_STATUS = 5'h17;
    localparam logic [PTR_W-1:0] IDX_CMD    = 5'h18;
    localparam logic [PTR_W-1:0] IDX_DATA   = 5'h19;
    localparam logic [PTR_W-1:0] IDX_AUX    = 5'h1A;

    localparam int AUX_INT_BIT = 7;
    localparam int AUX_CIP_BIT = 4;

    typedef enum logic [SEL_W-1:0] {
        PORT_INDEX = 2'd0,
        PORT_WIN   = 2'd1,
        PORT_RSV2  = 2'd2,
        PORT_RSV3  = 2'd3
    } port_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [PTR_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } win_acc_t;

    function automatic logic idx_holds(input logic [PTR_W-1:0] p);
        return (p == IDX_CMD) || (p == IDX_DATA) || (p == IDX_AUX);
    endfunction

endpackage

// File: rtl/regwin_index.sv
module regwin_index
    import regwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             step,
    output logic [PTR_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_val;
        end else if (step && !idx_holds(idx)) begin
            idx <= idx + 1'b1;
        end
    end

    assert_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !idx_holds(idx)) |=> (idx == $past(idx) + 1'b1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (step && !load && idx_holds(idx)) |=> $stable(idx));

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (idx == $past(load_val)));

endmodule

// File: rtl/regwin_bank.sv
module regwin_bank
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  win_acc_t          acc,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] aux,
    output logic              launch
);

    logic [DATA_W-1:0] regs     [NREG];
    logic [DATA_W-1:0] regs_nxt [NREG];

    logic hit_cmd, hit_cdb1, hit_status;

    always_comb begin
        hit_cmd    = acc.wr && (acc.idx == IDX_CMD);
        hit_cdb1   = acc.wr && (acc.idx == IDX_CDB1);
        hit_status = acc.rd && (acc.idx == IDX_STATUS);
    end

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            regs_nxt[i] = regs[i];
            if (acc.wr && (acc.idx == PTR_W'(i))) begin
                regs_nxt[i] = acc.data;
            end else if (PTR_W'(i) == IDX_AUX) begin
                if (hit_cmd)    regs_nxt[i][AUX_CIP_BIT] = 1'b1;
                if (hit_status) regs_nxt[i][AUX_INT_BIT] = 1'b0;
            end else if (PTR_W'(i) == IDX_PHASE) begin
                if (hit_cdb1) regs_nxt[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) regs[i] <= '0;
            else     regs[i] <= regs_nxt[i];
        end
    end

    assign rd_val = regs[acc.idx];
    assign aux    = regs[IDX_AUX];
    assign launch = hit_cmd;

    assert_cip_set_R6: assert property (@(posedge clk) disable iff (rst)
        hit_cmd |=> aux[AUX_CIP_BIT]);

    assert_phase_clr_R7: assert property (@(posedge clk) disable iff (rst)
        hit_cdb1 |=> (regs[IDX_PHASE] == '0));

    assert_int_clr_R8: assert property (@(posedge clk) disable iff (rst)
        (hit_status && !acc.wr) |=> !aux[AUX_INT_BIT]);

endmodule

// File: rtl/regwin_launch.sv
module regwin_launch
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fire,
    input  logic [DATA_W-1:0] byte_in,
    output logic              cmd_start,
    output logic [CODE_W-1:0] cmd_code
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_start <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_start <= fire;
            if (fire) cmd_code <= byte_in[CODE_W-1:0];
        end
    end

    assert_pulse_src_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_start |-> $past(fire));

    assert_code_R6: assert property (@(posedge clk) disable iff (rst)
        fire |=> (cmd_code == $past(byte_in[CODE_W-1:0])));

endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  port_sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_start,
    output logic [CODE_W-1:0] cmd_code,
    output logic              irq
);

    logic             rd_take;
    logic             idx_load;
    logic             win_touch;
    logic [PTR_W-1:0] idx;
    win_acc_t         acc;
    logic [DATA_W-1:0] win_val;
    logic [DATA_W-1:0] aux;
    logic             launch;

    always_comb begin
        rd_take   = rd_en && !wr_en;
        idx_load  = wr_en && (port_sel == PORT_INDEX);
        acc.wr    = wr_en && (port_sel == PORT_WIN);
        acc.rd    = rd_take && (port_sel == PORT_WIN);
        acc.idx   = idx;
        acc.data  = wr_data;
        win_touch = acc.wr || acc.rd;
    end

    regwin_index u_index (
        .clk      (clk),
        .rst      (rst),
        .load     (idx_load),
        .load_val (wr_data[PTR_W-1:0]),
        .step     (win_touch),
        .idx      (idx)
    );

    regwin_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .rd_val (win_val),
        .aux    (aux),
        .launch (launch)
    );

    regwin_launch u_launch (
        .clk       (clk),
        .rst       (rst),
        .fire      (launch),
        .byte_in   (wr_data),
        .cmd_start (cmd_start),
        .cmd_code  (cmd_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_take) begin
            unique case (port_sel)
                PORT_INDEX: rd_data <= aux;
                PORT_WIN:   rd_data <= win_val;
                default:    rd_data <= '0;
            endcase
        end
    end

    assign irq = aux[AUX_INT_BIT];

    assert_unused_rd_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_take && port_sel[1]) |=> (rd_data == '0));

    assert_unused_wr_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel[1]) |=> ($stable(idx) && $stable(aux) && !cmd_start));

    assert_aux_rd_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_take && port_sel == PORT_INDEX) |=> (rd_data == $past(aux)) && $stable(idx));

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !rd_take |=> $stable(rd_data));

endmodule

// File: tb/regwin_top_test.sv
module regwin_top_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] port_sel;
    logic       wr_en, rd_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       cmd_start;
    logic [6:0] cmd_code;
    logic       irq;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_top uut (
        .clk(clk), .rst(rst), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
        .wr_data(wr_data), .rd_data(rd_data), .cmd_start(cmd_start),
        .cmd_code(cmd_code), .irq(irq)
    );

    // entry: {req[3:0], is_read, sel[1:0], data[7:0], expect[7:0]}
    localparam int NVEC = 13;
    localparam logic [22:0] VEC [NVEC] = '{
        {4'd2,  1'b0, 2'd0, 8'hE5, 8'h00},  // R2: index <- 5
        {4'd4,  1'b0, 2'd1, 8'h11, 8'h00},  // R4: reg5
        {4'd4,  1'b0, 2'd1, 8'h22, 8'h00},  // R4: reg6
        {4'd2,  1'b0, 2'd0, 8'h05, 8'h00},
        {4'd4,  1'b1, 2'd1, 8'h00, 8'h11},
        {4'd4,  1'b1, 2'd1, 8'h00, 8'h22},
        {4'd2,  1'b0, 2'd0, 8'h1F, 8'h00},  // R4 wrap
        {4'd4,  1'b0, 2'd1, 8'h3C, 8'h00},
        {4'd4,  1'b0, 2'd1, 8'h4D, 8'h00},
        {4'd2,  1'b0, 2'd0, 8'hFF, 8'h00},  // R2: high bits dropped
        {4'd4,  1'b1, 2'd1, 8'h00, 8'h3C},
        {4'd4,  1'b1, 2'd1, 8'h00, 8'h4D},
        {4'd3,  1'b1, 2'd0, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        port_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel);
        @(negedge clk);
        port_sel = sel; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; port_sel = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 cmd_start", {7'd0, cmd_start}, 8'h00);
        rd(2'd1);
        check("R1 reg0", rd_data, 8'h00);
        rd(2'd0);
        check("R1 aux", rd_data, 8'h00);

        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][18]) begin
                rd(VEC[k][17:16]);
                check($sformatf("R%0d vec%0d", VEC[k][22:19], k), rd_data, VEC[k][7:0]);
            end else begin
                wr(VEC[k][17:16], VEC[k][15:8]);
            end
        end

        // R8: set interrupt via aux, R3 aux read ignores index
        wr(2'd0, 8'h07); wr(2'd1, 8'h5A);
        wr(2'd0, 8'h1A); wr(2'd1, 8'h80);
        check("R8 irq set", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h07);
        rd(2'd0);
        check("R3 aux via port0", rd_data, 8'h80);
        rd(2'd1);
        check("R3 index unchanged", rd_data, 8'h5A);

        // R5: data and aux registers hold the index
        wr(2'd0, 8'h19); wr(2'd1, 8'h66); wr(2'd1, 8'h77);
        rd(2'd1);
        check("R5 data hold", rd_data, 8'h77);
        rd(2'd1);
        check("R5 data hold again", rd_data, 8'h77);
        wr(2'd0, 8'h1A);
        rd(2'd1); rd(2'd1);
        check("R5 aux hold", rd_data, 8'h80);

        // R8: status read acknowledges interrupt
        wr(2'd0, 8'h17); wr(2'd1, 8'h42);
        check("R8 irq still set", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h17);
        rd(2'd1);
        check("R8 status value", rd_data, 8'h42);
        check("R8 irq cleared", {7'd0, irq}, 8'h00);
        rd(2'd0);
        check("R8 aux int clear", rd_data, 8'h00);

        // R6: command launch; index now 0x18 after status read (R4)
        @(negedge clk);
        port_sel = 2'd1; wr_data = 8'h85; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 pulse high", {7'd0, cmd_start}, 8'h01);
        check("R6 code", {1'b0, cmd_code}, 8'h05);
        @(negedge clk);
        check("R6 pulse one cycle", {7'd0, cmd_start}, 8'h00);
        rd(2'd0);
        check("R6 cip set", rd_data, 8'h10);
        rd(2'd1);
        check("R6 cmd stored", rd_data, 8'h85);

        // R7: descriptor byte write clears phase
        wr(2'd0, 8'h10); wr(2'd1, 8'h33);
        wr(2'd0, 8'h10); rd(2'd1);
        check("R7 phase preset", rd_data, 8'h33);
        wr(2'd0, 8'h03); wr(2'd1, 8'h01);
        wr(2'd0, 8'h10); rd(2'd1);
        check("R7 phase cleared", rd_data, 8'h00);

        // R9: unused locations
        wr(2'd0, 8'h05);
        wr(2'd2, 8'h18); wr(2'd3, 8'h44);
        check("R9 no launch", {7'd0, cmd_start}, 8'h00);
        rd(2'd2);
        check("R9 read sel2", rd_data, 8'h00);
        rd(2'd3);
        check("R9 read sel3", rd_data, 8'h00);
        rd(2'd1);
        check("R9 index/reg untouched", rd_data, 8'h11);

        // R10: read data holds between reads
        repeat (3) @(negedge clk);
        check("R10 hold", rd_data, 8'h11);
        wr(2'd1, 8'hAB);
        check("R10 hold across write", rd_data, 8'h11);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule